// File: doc/BRIEF.md
# Byte-Serial SPI Controller with Master Contention Fault

This block moves 8-bit frames over a four-wire serial link and can act either as the clock-driving master or as a responding slave. Software sets it up through a control word: enable, master select, interrupt enable, clock polarity, clock phase and a clock divider. A write of the data word starts a master frame, or preloads the reply byte in slave mode. The received byte, a completion flag and an interrupt line report the result of each frame.

While it is master, the block watches its own slave-select input. If another device drives that input low, the two devices are fighting over the bus. The block then records a fault, clears its own enable and master bits, and releases every output it drives. It stays locked in that state until software reads the status word and then rewrites the control word.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control word (`ctrl_rdata`) and status word (`stat_rdata`) read 0, `irq` is 0, `sck_o` is 0, and `sck_oe`, `mosi_oe` and `miso_oe` are all 0.
- R2: When the block is enabled as master and idle, a data write sends the byte most significant bit first on `mosi_o`. The frame uses exactly 16 `sck_o` edges, and each bit is stable at the edge where it is captured.
- R3: `sck_o` rests at the polarity bit whenever no master frame is running. During a frame, each half period of `sck_o` lasts divider+1 system clock cycles, counted from the data write to the first edge and between edges.
- R4: With the phase bit at 0, bits are captured on the first edge of each bit (the edge that leaves the rest level). With the phase bit at 1, they are captured on the second edge. In master mode, `rx_data` holds the 8 bits sampled from `miso_i` at the capture edges, first bit in bit 7.
- R5: Status bit 0 (done) is set when the eighth bit of a frame has been captured and is cleared by a data write. `irq` is high while done is set and the interrupt-enable bit is 1, and low when the interrupt-enable bit is 0.
- R6: In slave mode with `ss_n_i` high, `miso_oe` is 0 and the reply register is reloaded from the last data write. With `ss_n_i` low, `miso_oe` is 1, that byte goes out most significant bit first on `miso_o`, and the byte seen on `mosi_i` at the capture edges of `sck_i` lands in `rx_data`.
- R7: While the block is enabled as master, a low level on `ss_n_i` (after its synchronizer) sets status bit 1 (fault). It also clears control bits 0 (enable) and 1 (master) and drops `sck_oe`, `mosi_oe` and `miso_oe` to 0.
- R8: While fault is set and the interrupt-enable bit is 1, `irq` is high.
- R9: Fault stays set until a status read (`stat_rd`) is followed by a control write, and that write clears it. Any control write made while fault is set stores 0 into enable and master. The next write after the clear takes effect normally.
- R10: A control write made while enable is 1 leaves polarity (bit 3), phase (bit 4) and divider (bits 7:5) unchanged. Only enable, master and interrupt enable (bit 2) are updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word: bit0 enable, bit1 master, bit2 irq enable, bit3 polarity, bit4 phase, bits7:5 divider |
| ctrl_rdata | output | 8 | Current control word, same layout |
| stat_rd | input | 1 | Status read strobe (arms fault clearing) |
| stat_rdata | output | 2 | Status: bit0 done, bit1 fault |
| data_wr | input | 1 | Data write strobe (starts master frame / loads slave reply) |
| data_wdata | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave side) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master side) |
| ss_n_i | input | 1 | Active-low slave select input |

## Verification
Master frames run in all four polarity/phase combinations, each with a different byte (0xA5, 0x3C, 0x81, 0x6E), plus a fast divider with 0xFF and a slow divider with 0x00. The data line is looped back inverted, so the received byte differs from the sent one and a wrong capture edge or wrong bit order shows up as a mismatch. Slave frames in all four modes use different reply and incoming bytes, which separates what the block drives from what it captures. The fault sequence checks the lockout, the ignored rewrites, the two-step clear and the recovery that follows it.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
   // control word bit positions (decoded by software and by the register block)
   localparam int CB_EN   = 0;
   localparam int CB_MST  = 1;
   localparam int CB_IRQ  = 2;
   localparam int CB_CPOL = 3;
   localparam int CB_CPHA = 4;
   localparam int CB_DIV  = 5;
   // status word bit positions
   localparam int SB_DONE  = 0;
   localparam int SB_FAULT = 1;

   typedef struct packed {
      logic cpha;
      logic cpol;
      logic irq_en;
      logic master;
      logic en;
   } mode_cfg_t;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_mf_regs.sv
module spi_mf_regs
   import spi_mf_pkg::*;
#(
   parameter  int DIV_W  = 3,
   localparam int CTRL_W = CB_DIV + DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              stat_rd,
   input  logic              data_wr,
   input  logic              xfer_done,
   input  logic              fault_det,
   output mode_cfg_t         cfg,
   output logic [DIV_W-1:0]  div,
   output logic              done_flag,
   output logic              fault_flag,
   output logic              irq
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg        <= '0;
         div        <= '0;
         done_flag  <= 1'b0;
         fault_flag <= 1'b0;
         armed      <= 1'b0;
      end else begin
         if (xfer_done)    done_flag <= 1'b1;
         else if (data_wr) done_flag <= 1'b0;

         if (fault_det) begin
            cfg.en     <= 1'b0;
            cfg.master <= 1'b0;
            fault_flag <= 1'b1;
            armed      <= 1'b0;
         end else if (ctrl_wr) begin
            cfg.en     <= ctrl_wdata[CB_EN]  & ~fault_flag;
            cfg.master <= ctrl_wdata[CB_MST] & ~fault_flag;
            cfg.irq_en <= ctrl_wdata[CB_IRQ];
            if (!cfg.en) begin
               cfg.cpol <= ctrl_wdata[CB_CPOL];
               cfg.cpha <= ctrl_wdata[CB_CPHA];
               div      <= ctrl_wdata[CB_DIV +: DIV_W];
            end
            if (armed) begin
               fault_flag <= 1'b0;
               armed      <= 1'b0;
            end
         end else if (stat_rd && fault_flag) begin
            armed <= 1'b1;
         end
      end
   end

   assign irq = cfg.irq_en & (done_flag | fault_flag);

   // R7
   fault_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_det |=> fault_flag && !cfg.en && !cfg.master);
   // R9
   fault_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag && ctrl_wr |=> !cfg.en && !cfg.master);
   // R9
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag && !ctrl_wr |=> fault_flag);
   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.en |=> $stable(cfg.cpol) && $stable(cfg.cpha) && $stable(div));
endmodule

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic             cpol,
   output logic             tick,
   output logic             phase,
   output logic             sck_lvl
);
   logic [DIV_W-1:0] cnt;

   assign tick    = run && (cnt == div);
   assign sck_lvl = cpol ^ phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (tick) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2
   phase_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> !phase);
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
   parameter  int FRAME_W = 8,
   localparam int CNT_W   = $clog2(FRAME_W),
   localparam int ECNT_W  = $clog2(2 * FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               master,
   input  logic               cpol,
   input  logic               cpha,
   input  logic               data_wr,
   input  logic [FRAME_W-1:0] data_wdata,
   input  logic               tick,
   input  logic               phase,
   input  logic               miso_in,
   input  logic               s_sck,
   input  logic               s_mosi,
   input  logic               s_ss_n,
   output logic               busy,
   output logic               out_bit,
   output logic [FRAME_W-1:0] rx_data,
   output logic               xfer_done
);
   logic [FRAME_W-1:0] sr, rx_sh, txbuf;
   logic [CNT_W-1:0]   cnt;
   logic [ECNT_W-1:0]  ecnt;
   logic               sck_prev;
   logic               m_act, s_act, start, s_chg, lead, trail, cap, launch, in_bit;

   assign m_act  = en & master;
   assign s_act  = en & ~master & ~s_ss_n;
   assign start  = m_act & data_wr & ~busy;
   assign s_chg  = s_sck ^ sck_prev;
   assign lead   = m_act ? (tick & ~phase) : (s_act & s_chg & (s_sck != cpol));
   assign trail  = m_act ? (tick & phase)  : (s_act & s_chg & (s_sck == cpol));
   assign cap    = cpha ? trail : lead;
   assign launch = cpha ? lead : trail;
   assign in_bit = master ? miso_in : s_mosi;
   assign out_bit = sr[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '0;
         rx_sh     <= '0;
         txbuf     <= '0;
         rx_data   <= '0;
         cnt       <= '0;
         ecnt      <= '0;
         busy      <= 1'b0;
         sck_prev  <= 1'b0;
         xfer_done <= 1'b0;
      end else begin
         xfer_done <= 1'b0;
         sck_prev  <= s_sck;
         if (data_wr) txbuf <= data_wdata;
         if (!m_act)  busy  <= 1'b0;

         if (start) begin
            busy  <= 1'b1;
            sr    <= data_wdata;
            rx_sh <= '0;
            cnt   <= '0;
            ecnt  <= '0;
         end else if (!m_act && !s_act) begin
            sr  <= txbuf;
            cnt <= '0;
         end else begin
            if (m_act && tick) begin
               ecnt <= ecnt + 1'b1;
               if (ecnt == ECNT_W'(2 * FRAME_W - 1)) busy <= 1'b0;
            end
            if (cap) begin
               if (cnt == CNT_W'(FRAME_W - 1)) begin
                  rx_data   <= {rx_sh[FRAME_W-2:0], in_bit};
                  xfer_done <= 1'b1;
                  cnt       <= '0;
               end else begin
                  rx_sh <= {rx_sh[FRAME_W-2:0], in_bit};
                  cnt   <= cnt + 1'b1;
               end
            end
            if (launch && cnt != '0) sr <= {sr[FRAME_W-2:0], 1'b0};
         end
      end
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);
   // R6
   slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !master && s_ss_n |=> cnt == '0);
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
   import spi_mf_pkg::*;
#(
   parameter  int FRAME_W     = 8,
   parameter  int DIV_W       = 3,
   parameter  int SYNC_STAGES = 2,
   localparam int CTRL_W      = CB_DIV + DIV_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic [CTRL_W-1:0]  ctrl_wdata,
   output logic [CTRL_W-1:0]  ctrl_rdata,
   input  logic               stat_rd,
   output logic [1:0]         stat_rdata,
   input  logic               data_wr,
   input  logic [FRAME_W-1:0] data_wdata,
   output logic [FRAME_W-1:0] rx_data,
   output logic               irq,
   output logic               sck_o,
   output logic               sck_oe,
   input  logic               sck_i,
   output logic               mosi_o,
   output logic               mosi_oe,
   input  logic               mosi_i,
   output logic               miso_o,
   output logic               miso_oe,
   input  logic               miso_i,
   input  logic               ss_n_i
);
   localparam int         N_SYNC   = 3;
   localparam logic [2:0] SYNC_RST = 3'b100; // ss idles high, sck/mosi low

   if (FRAME_W < 2)     begin : g_bad_frame $error("FRAME_W must be at least 2"); end
   if (DIV_W < 1)       begin : g_bad_div   $error("DIV_W must be at least 1"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   mode_cfg_t         cfg;
   logic [DIV_W-1:0]  div;
   logic              done_flag, fault_flag, fault_det, xfer_done;
   logic              tick, phase, sck_lvl, busy, out_bit;
   logic [N_SYNC-1:0] raw_in, synced;
   logic              s_sck, s_mosi, s_ss_n;

   assign raw_in = {ss_n_i, mosi_i, sck_i};
   for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
      spi_mf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
         .clk (clk), .rst_n (rst_n), .d (raw_in[g]), .q (synced[g]));
   end
   assign s_sck  = synced[0];
   assign s_mosi = synced[1];
   assign s_ss_n = synced[2];

   assign fault_det = cfg.en & cfg.master & ~s_ss_n;

   spi_mf_regs #(.DIV_W(DIV_W)) u_regs (
      .clk (clk), .rst_n (rst_n), .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata),
      .stat_rd (stat_rd), .data_wr (data_wr), .xfer_done (xfer_done),
      .fault_det (fault_det), .cfg (cfg), .div (div), .done_flag (done_flag),
      .fault_flag (fault_flag), .irq (irq));

   spi_mf_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk (clk), .rst_n (rst_n), .run (busy), .div (div), .cpol (cfg.cpol),
      .tick (tick), .phase (phase), .sck_lvl (sck_lvl));

   spi_mf_shifter #(.FRAME_W(FRAME_W)) u_shifter (
      .clk (clk), .rst_n (rst_n), .en (cfg.en), .master (cfg.master),
      .cpol (cfg.cpol), .cpha (cfg.cpha), .data_wr (data_wr),
      .data_wdata (data_wdata), .tick (tick), .phase (phase), .miso_in (miso_i),
      .s_sck (s_sck), .s_mosi (s_mosi), .s_ss_n (s_ss_n), .busy (busy),
      .out_bit (out_bit), .rx_data (rx_data), .xfer_done (xfer_done));

   always_comb begin
      ctrl_rdata                   = '0;
      ctrl_rdata[CB_EN]            = cfg.en;
      ctrl_rdata[CB_MST]           = cfg.master;
      ctrl_rdata[CB_IRQ]           = cfg.irq_en;
      ctrl_rdata[CB_CPOL]          = cfg.cpol;
      ctrl_rdata[CB_CPHA]          = cfg.cpha;
      ctrl_rdata[CB_DIV +: DIV_W]  = div;
      stat_rdata                   = '0;
      stat_rdata[SB_DONE]          = done_flag;
      stat_rdata[SB_FAULT]         = fault_flag;
   end

   assign sck_o   = sck_lvl;
   assign sck_oe  = cfg.en & cfg.master;
   assign mosi_o  = out_bit;
   assign mosi_oe = cfg.en & cfg.master;
   assign miso_o  = out_bit;
   assign miso_oe = cfg.en & ~cfg.master & ~s_ss_n;

   // R7
   fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> !sck_oe && !mosi_oe && !miso_oe);
   // R8
   fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag && cfg.irq_en |-> irq);
   // R3
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o == cfg.cpol);
   // R6
   no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sck_oe && miso_oe));
endmodule

// File: tb/spi_mf_ctrl_bench.sv
module spi_mf_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 8;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       ctrl_wr = 1'b0, stat_rd = 1'b0, data_wr = 1'b0;
   logic [7:0] ctrl_wdata = '0, ctrl_rdata, data_wdata = '0, rx_data;
   logic [1:0] stat_rdata;
   logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
   logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

   int         n_cmp = 0, n_bad = 0;
   logic [7:0] exp_q[$];
   logic [7:0] exp_b;
   logic       prev_done = 1'b0;
   logic [7:0] mpat [4] = '{8'hA5, 8'h3C, 8'h81, 8'h6E};
   logic [7:0] spat [4] = '{8'hC3, 8'h5A, 8'h0F, 8'h92};
   logic [7:0] sin  [4] = '{8'h17, 8'hE8, 8'hB4, 8'h29};

   // inverted loopback: the master receives the complement of what it sends
   assign miso_i = ~mosi_o;

   spi_mf_ctrl u_spi_mf_ctrl (
      .clk (clk), .rst_n (rst_n), .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata),
      .ctrl_rdata (ctrl_rdata), .stat_rd (stat_rd), .stat_rdata (stat_rdata),
      .data_wr (data_wr), .data_wdata (data_wdata), .rx_data (rx_data), .irq (irq),
      .sck_o (sck_o), .sck_oe (sck_oe), .sck_i (sck_i), .mosi_o (mosi_o),
      .mosi_oe (mosi_oe), .mosi_i (mosi_i), .miso_o (miso_o), .miso_oe (miso_oe),
      .miso_i (miso_i), .ss_n_i (ss_n_i));

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] mk(input logic en, input logic mst, input logic ie,
                                     input logic cpol, input logic cpha, input logic [2:0] dv);
      return {dv, cpha, cpol, ie, mst, en};
   endfunction

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wdata = v; ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      data_wdata = v; data_wr = 1'b1;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   // scoreboard monitor: pops an expected byte on every rising done flag
   always @(negedge clk) begin
      prev_done <= stat_rdata[0];
      if (rst_n && stat_rdata[0] && !prev_done) begin
         if (exp_q.size() == 0) check("R5 done with no frame expected", 1, 0);
         else begin
            exp_b = exp_q.pop_front();
            check("R4 R6 received byte", rx_data, exp_b);
         end
      end
   end

   task automatic master_xfer(input logic [7:0] tx, input logic cpol, input logic cpha,
                              input int dv);
      int edges = 0, since = 0, guard = 0, bad_half = 0;
      logic last;
      logic [7:0] got = '0;
      exp_q.push_back(~tx);
      wr_data(tx);
      check("R5 done cleared by data write", stat_rdata[0], 0);
      last = sck_o;
      while (edges < 16 && guard < 4000) begin
         @(negedge clk);
         guard++; since++;
         if (sck_o !== last) begin
            edges++;
            if (since != dv + 1) bad_half++;
            since = 0;
            last  = sck_o;
            if ((edges % 2 == 1) != cpha) got = {got[6:0], mosi_o};
         end
      end
      check("R2 sck edge count", edges, 16);
      check("R2 mosi byte msb first", got, tx);
      check("R3 half period mismatches", bad_half, 0);
      bad_half = 0;
      repeat (3 * (dv + 1) + 4) begin
         @(negedge clk);
         if (sck_o !== cpol) bad_half++;
      end
      check("R3 sck rests at polarity after frame", bad_half, 0);
      check("R5 done set after frame", stat_rdata[0], 1);
   endtask

   task automatic slave_xfer(input logic [7:0] txs, input logic [7:0] rxm,
                             input logic cpol, input logic cpha);
      logic [7:0] got = '0;
      wr_data(txs);
      exp_q.push_back(rxm);
      sck_i = cpol;
      cyc(4);
      check("R6 miso released while deselected", miso_oe, 0);
      ss_n_i = 1'b0;
      cyc(H);
      check("R6 miso driven while selected", miso_oe, 1);
      for (int i = 7; i >= 0; i--) begin
         if (!cpha) begin
            mosi_i = rxm[i]; cyc(H);
            got = {got[6:0], miso_o};
            sck_i = ~cpol; cyc(H);
            sck_i = cpol;  cyc(H);
         end else begin
            sck_i = ~cpol; cyc(H);
            mosi_i = rxm[i]; cyc(H);
            got = {got[6:0], miso_o};
            sck_i = cpol;  cyc(H);
         end
      end
      check("R6 slave reply msb first", got, txs);
      ss_n_i = 1'b1;
      cyc(6);
      check("R6 miso released after deselect", miso_oe, 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      check("R1 ctrl after reset", ctrl_rdata, 0);
      check("R1 status after reset", stat_rdata, 0);
      check("R1 irq after reset", irq, 0);
      check("R1 sck after reset", sck_o, 0);
      check("R1 enables after reset", {sck_oe, mosi_oe, miso_oe}, 0);

      // master frames, all four polarity/phase modes
      for (int m = 0; m < 4; m++) begin
         wr_ctrl(8'h00);
         wr_ctrl(mk(0, 0, 1, m[1], m[0], 3'd2));
         wr_ctrl(mk(1, 1, 1, m[1], m[0], 3'd2));
         check("R3 idle level follows polarity", sck_o, m[1]);
         master_xfer(mpat[m], m[1], m[0], 2);
         check("R5 irq with done", irq, 1);
      end
      wr_ctrl(8'h00);
      wr_ctrl(mk(0, 0, 1, 0, 0, 3'd0));
      wr_ctrl(mk(1, 1, 1, 0, 0, 3'd0));
      master_xfer(8'hFF, 0, 0, 0);
      wr_ctrl(8'h00);
      wr_ctrl(mk(0, 0, 0, 1, 1, 3'd5));
      wr_ctrl(mk(1, 1, 0, 1, 1, 3'd5));
      master_xfer(8'h00, 1, 1, 5);
      check("R5 irq masked when disabled", irq, 0);

      // R10 mode bits locked while enabled
      wr_ctrl(mk(1, 1, 0, 0, 0, 3'd1));
      check("R10 mode bits unchanged while enabled", ctrl_rdata, mk(1, 1, 0, 1, 1, 3'd5));
      check("R10 sck keeps old polarity", sck_o, 1);

      // slave frames, all four modes
      for (int m = 0; m < 4; m++) begin
         wr_ctrl(8'h00);
         wr_ctrl(mk(0, 0, 1, m[1], m[0], 3'd0));
         wr_ctrl(mk(1, 0, 1, m[1], m[0], 3'd0));
         slave_xfer(spat[m], sin[m], m[1], m[0]);
      end

      // mode fault
      wr_ctrl(8'h00);
      wr_data(8'h00);
      wr_ctrl(mk(0, 1, 1, 0, 0, 3'd1));
      wr_ctrl(mk(1, 1, 1, 0, 0, 3'd1));
      check("R8 irq quiet before fault", irq, 0);
      check("R7 outputs driven as master", {sck_oe, mosi_oe}, 2'b11);
      ss_n_i = 1'b0;
      cyc(4);
      check("R7 fault flag set", stat_rdata[1], 1);
      check("R7 enable and master cleared", ctrl_rdata[1:0], 0);
      check("R7 outputs released", {sck_oe, mosi_oe, miso_oe}, 0);
      check("R8 irq on fault", irq, 1);
      ss_n_i = 1'b1;
      cyc(3);
      wr_ctrl(mk(1, 1, 1, 0, 0, 3'd1));
      check("R9 write blocked while fault set", ctrl_rdata[1:0], 0);
      check("R9 fault kept without status read", stat_rdata[1], 1);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R9 fault kept after read alone", stat_rdata[1], 1);
      wr_ctrl(mk(1, 1, 1, 0, 0, 3'd1));
      check("R9 fault cleared by read then write", stat_rdata[1], 0);
      check("R9 clearing write still blocked", ctrl_rdata[1:0], 0);
      wr_ctrl(mk(1, 1, 1, 0, 0, 3'd1));
      check("R9 master restored after clear", ctrl_rdata[1:0], 2'b11);
      master_xfer(8'h4D, 0, 0, 1);

      cyc(10);
      check("R5 scoreboard drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule